// File: doc/BRIEF.md
# Dual-Slot Instruction Issue Sequencer

This block sits between instruction fetch and the execution lanes of a two-lane core. Each fetched 32-bit word carries a 2-bit format field in its top bits. The word holds either one 30-bit long operation or two 15-bit short operations, one for a left lane and one for a right lane. The sequencer latches the word and picks the issue order. It sends each operation to its lane with a one-cycle issue strobe and waits for that lane's done pulse before it moves on. Depending on the format and on the flags returned with the first completion, it either issues the partner operation or suppresses it.

In the two ordered formats, the partner runs only if the first operation neither redirected the program counter nor raised an exception. Between the two issues a one-cycle flush request lets pending writebacks drain. In the parallel format, an external decoder marks each short operation as test-only or not. A test-only operation runs first, and its condition result decides whether the other operation runs at all. Single-cycle event strobes report every outcome to statistics counters, and a word-done pulse tells fetch that the sequencer is free for the next word. The operations themselves are executed elsewhere.

Top module: `slot_issue_seq`

## Requirements
- R1: While reset is high, and in the cycle after it is released, no issue strobe, flush request, word-done or event strobe is asserted.
- R2: Format 2'b11 (bits 31:30) issues one long operation equal to bits 29:0, with lookup key bits 29:24, on the long issue strobe, and pulses the long event. Its completion is reported on the left lane's done inputs.
- R3: The left short operation is bits 29:15 and the right short operation is bits 14:0. Each short lookup key is bits 14:9 of its own 15-bit operation.
- R4: Format 2'b01 issues the left operation first and the right one second, and pulses the left-then-right event in the cycle of the first issue.
- R5: Format 2'b10 issues the right operation first and the left one second, and pulses the right-then-left event in the cycle of the first issue.
- R6: In the ordered formats, the second operation is suppressed when the first reports a PC change or an exception. A suppression caused by a PC change alone pulses the conditional-jump event in the word-done cycle. A suppression caused by an exception gives no such pulse.
- R7: In the ordered formats, when the second operation is allowed, a single flush-request cycle comes after the first done and immediately before the second issue.
- R8: Format 2'b00 with the left operation marked test-only, whether or not the right one is also marked, issues left first. On a true condition result it pulses cond-true together with the right issue. On a false result it pulses cond-false in the word-done cycle and never issues right.
- R9: Format 2'b00 with only the right operation marked test-only issues right first. It then gates the left operation on the right operation's condition result, with the same cond-true and cond-false pulses as R8.
- R10: Format 2'b00 with neither operation marked test-only issues left then right with no flush request, unless left reports an exception. In that case right is suppressed.
- R11: Each issue strobe lasts exactly one cycle and at most one lane is issued per cycle. The next issue waits for the issued lane's done. Word-done pulses for one cycle, one cycle after the final done or after the done that caused the suppression.
- R12: A fetch-valid strobe that arrives while a word is still in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetchValid | input | 1 | Fetched word present; accepted only when idle |
| fetchWord | input | 32 | Fetched instruction word |
| leftTestOnly | input | 1 | Decoder flag: left short op is a test-only kind |
| rightTestOnly | input | 1 | Decoder flag: right short op is a test-only kind |
| leftDone | input | 1 | Left lane (or long op) completion pulse |
| leftPcChanged | input | 1 | Left completion redirected the PC |
| leftExcept | input | 1 | Left completion raised an exception |
| leftCondTrue | input | 1 | Left test result |
| rightDone | input | 1 | Right lane completion pulse |
| rightPcChanged | input | 1 | Right completion redirected the PC |
| rightExcept | input | 1 | Right completion raised an exception |
| rightCondTrue | input | 1 | Right test result |
| issueLong | output | 1 | Long operation issue strobe |
| longOp | output | 30 | Long operation payload |
| longKey | output | 6 | Long operation lookup key |
| issueLeft | output | 1 | Left lane issue strobe |
| leftOp | output | 15 | Left short operation |
| leftKey | output | 6 | Left lookup key |
| issueRight | output | 1 | Right lane issue strobe |
| rightOp | output | 15 | Right short operation |
| rightKey | output | 6 | Right lookup key |
| flushReq | output | 1 | Writeback flush request between ordered issues |
| wordDone | output | 1 | Word finished pulse |
| evLong | output | 1 | Event: long word |
| evLeftRight | output | 1 | Event: left-then-right word |
| evRightLeft | output | 1 | Event: right-then-left word |
| evParallel | output | 1 | Event: parallel word |
| evCondTrue | output | 1 | Event: test passed, partner issued |
| evCondFalse | output | 1 | Event: test failed, partner skipped |
| evCondJump | output | 1 | Event: partner skipped after a PC change |

## Verification
The bench goes after suppression of the second lane. An ordered pair whose first operation redirects the PC must skip the partner and report a conditional jump. An exception must skip the partner silently, and a design that mixed these up would report a jump that never happened or drop the count. In parallel words the bench marks left, right, both or neither operation as test-only. A design with the priority reversed would issue the wrong lane first, and one that ignored a false condition would issue an operation that should have been discarded. The bench also fires a fetch strobe in the middle of a busy word, which a design without that guard would start as a spurious new word. It checks that the flush request appears only in ordered pairs.

// File: rtl/issue_pkg.sv
package issue_pkg;

  typedef enum logic [1:0] {
    FMT_PAR  = 2'b00,
    FMT_LR   = 2'b01,
    FMT_RL   = 2'b10,
    FMT_LONG = 2'b11
  } fmt_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ISSUE1,
    S_WAIT1,
    S_FLUSH,
    S_ISSUE2,
    S_WAIT2,
    S_FIN
  } seq_st_e;

  // strobes from the sequencing control into the word datapath
  typedef struct packed {
    logic loadWord;
    logic issueLong;
    logic issueLeft;
    logic issueRight;
  } dp_ctl_t;

endpackage

// File: rtl/issue_dp.sv
module issue_dp
  import issue_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int SHORT_W = 15,
  parameter int KEY_W   = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  dp_ctl_t             ctl,
  input  logic [WORD_W-1:0]   fetchWord,
  output fmt_e                fmt,
  output logic [WORD_W-3:0]   longOp,
  output logic [KEY_W-1:0]    longKey,
  output logic [SHORT_W-1:0]  leftOp,
  output logic [KEY_W-1:0]    leftKey,
  output logic [SHORT_W-1:0]  rightOp,
  output logic [KEY_W-1:0]    rightKey,
  output logic                issueLong,
  output logic                issueLeft,
  output logic                issueRight
);
  localparam int LONG_W   = WORD_W - 2;
  localparam int NUM_SLOT = 2;

  logic [WORD_W-1:0]  wordQ;
  logic [SHORT_W-1:0] shortOp  [NUM_SLOT];
  logic [KEY_W-1:0]   shortKey [NUM_SLOT];

  always_ff @(posedge clk) begin
    if (rst) begin
      wordQ <= '0;
    end else if (ctl.loadWord) begin
      wordQ <= fetchWord;
    end
  end

  assign fmt     = fmt_e'(wordQ[WORD_W-1 -: 2]);
  assign longOp  = wordQ[LONG_W-1:0];
  assign longKey = longOp[LONG_W-1 -: KEY_W];

  // slot 0 is the right lane (low bits), slot 1 the left lane
  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    assign shortOp[s]  = wordQ[s*SHORT_W +: SHORT_W];
    assign shortKey[s] = shortOp[s][SHORT_W-1 -: KEY_W];
  end

  assign rightOp  = shortOp[0];
  assign rightKey = shortKey[0];
  assign leftOp   = shortOp[1];
  assign leftKey  = shortKey[1];

  assign issueLong  = ctl.issueLong;
  assign issueLeft  = ctl.issueLeft;
  assign issueRight = ctl.issueRight;

endmodule

// File: rtl/issue_ctrl.sv
module issue_ctrl
  import issue_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    fetchValid,
  input  fmt_e    fmt,
  input  logic    leftTestOnly,
  input  logic    rightTestOnly,
  input  logic    leftDone,
  input  logic    leftPcChanged,
  input  logic    leftExcept,
  input  logic    leftCondTrue,
  input  logic    rightDone,
  input  logic    rightPcChanged,
  input  logic    rightExcept,
  input  logic    rightCondTrue,
  output dp_ctl_t ctl,
  output logic    flushReq,
  output logic    wordDone,
  output logic    evLong,
  output logic    evLeftRight,
  output logic    evRightLeft,
  output logic    evParallel,
  output logic    evCondTrue,
  output logic    evCondFalse,
  output logic    evCondJump
);
  seq_st_e state, nextState;
  logic firstRight, testMode;
  logic firstRightNow, testModeNow;
  logic done1, pc1, exc1, cond1, done2;
  logic ctNext, cfNext, cjNext;

  // lane order chosen while the first issue is on the wires
  assign testModeNow   = (fmt == FMT_PAR) && (leftTestOnly || rightTestOnly);
  assign firstRightNow = (fmt == FMT_RL) ||
                         ((fmt == FMT_PAR) && !leftTestOnly && rightTestOnly);

  // completion of the first and second lane
  assign done1 = firstRight ? rightDone      : leftDone;
  assign pc1   = firstRight ? rightPcChanged : leftPcChanged;
  assign exc1  = firstRight ? rightExcept    : leftExcept;
  assign cond1 = firstRight ? rightCondTrue  : leftCondTrue;
  assign done2 = firstRight ? leftDone       : rightDone;

  always_comb begin
    nextState = state;
    ctNext    = 1'b0;
    cfNext    = 1'b0;
    cjNext    = 1'b0;
    case (state)
      S_IDLE:   if (fetchValid) nextState = S_ISSUE1;
      S_ISSUE1: nextState = S_WAIT1;
      S_WAIT1: begin
        if (done1) begin
          case (fmt)
            FMT_LONG: nextState = S_FIN;
            FMT_LR, FMT_RL: begin
              if (!pc1 && !exc1) begin
                nextState = S_FLUSH;
              end else begin
                nextState = S_FIN;
                cjNext    = !exc1;
              end
            end
            default: begin
              if (testMode) begin
                if (cond1) begin
                  nextState = S_ISSUE2;
                  ctNext    = 1'b1;
                end else begin
                  nextState = S_FIN;
                  cfNext    = 1'b1;
                end
              end else begin
                nextState = exc1 ? S_FIN : S_ISSUE2;
              end
            end
          endcase
        end
      end
      S_FLUSH:  nextState = S_ISSUE2;
      S_ISSUE2: nextState = S_WAIT2;
      S_WAIT2:  if (done2) nextState = S_FIN;
      S_FIN:    nextState = S_IDLE;
      default:  nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      firstRight <= 1'b0;
      testMode   <= 1'b0;
      evCondTrue <= 1'b0;
      evCondFalse <= 1'b0;
      evCondJump <= 1'b0;
    end else begin
      state       <= nextState;
      evCondTrue  <= ctNext;
      evCondFalse <= cfNext;
      evCondJump  <= cjNext;
      if (state == S_ISSUE1) begin
        firstRight <= firstRightNow;
        testMode   <= testModeNow;
      end
    end
  end

  logic inIssue1;
  assign inIssue1 = (state == S_ISSUE1);

  always_comb begin
    ctl            = '0;
    ctl.loadWord   = (state == S_IDLE) && fetchValid;
    ctl.issueLong  = inIssue1 && (fmt == FMT_LONG);
    ctl.issueLeft  = (inIssue1 && (fmt != FMT_LONG) && !firstRightNow) ||
                     ((state == S_ISSUE2) && firstRight);
    ctl.issueRight = (inIssue1 && (fmt != FMT_LONG) && firstRightNow) ||
                     ((state == S_ISSUE2) && !firstRight);
  end

  assign flushReq    = (state == S_FLUSH);
  assign wordDone    = (state == S_FIN);
  assign evLong      = inIssue1 && (fmt == FMT_LONG);
  assign evLeftRight = inIssue1 && (fmt == FMT_LR);
  assign evRightLeft = inIssue1 && (fmt == FMT_RL);
  assign evParallel  = inIssue1 && (fmt == FMT_PAR);

  // R11: one lane per cycle
  assert_single_issue_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.issueLong, ctl.issueLeft, ctl.issueRight}));

  // R11: issue strobes are single-cycle pulses
  assert_issue_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    (ctl.issueLong || ctl.issueLeft || ctl.issueRight) |=>
      !(ctl.issueLong || ctl.issueLeft || ctl.issueRight));

  // R11: word-done follows a lane completion
  assert_done_after_lane_R11: assert property (@(posedge clk) disable iff (rst)
    wordDone |-> $past(leftDone || rightDone));

  // R7: the flush cycle leads straight into the second issue
  assert_flush_then_issue_R7: assert property (@(posedge clk) disable iff (rst)
    flushReq |=> (ctl.issueLeft || ctl.issueRight));

  // R8: a failed test ends the word at once
  assert_cond_false_ends_R8: assert property (@(posedge clk) disable iff (rst)
    evCondFalse |-> wordDone);

  // R6: a jump skip ends the word at once
  assert_cond_jump_ends_R6: assert property (@(posedge clk) disable iff (rst)
    evCondJump |-> wordDone);

  // R12: a fetch while busy starts nothing new
  assert_fetch_ignored_R12: assert property (@(posedge clk) disable iff (rst)
    (fetchValid && (state != S_IDLE)) |-> !ctl.loadWord);

endmodule

// File: rtl/slot_issue_seq.sv
module slot_issue_seq
  import issue_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int SHORT_W = 15,
  parameter int KEY_W   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fetchValid,
  input  logic [WORD_W-1:0]  fetchWord,
  input  logic               leftTestOnly,
  input  logic               rightTestOnly,
  input  logic               leftDone,
  input  logic               leftPcChanged,
  input  logic               leftExcept,
  input  logic               leftCondTrue,
  input  logic               rightDone,
  input  logic               rightPcChanged,
  input  logic               rightExcept,
  input  logic               rightCondTrue,
  output logic               issueLong,
  output logic [WORD_W-3:0]  longOp,
  output logic [KEY_W-1:0]   longKey,
  output logic               issueLeft,
  output logic [SHORT_W-1:0] leftOp,
  output logic [KEY_W-1:0]   leftKey,
  output logic               issueRight,
  output logic [SHORT_W-1:0] rightOp,
  output logic [KEY_W-1:0]   rightKey,
  output logic               flushReq,
  output logic               wordDone,
  output logic               evLong,
  output logic               evLeftRight,
  output logic               evRightLeft,
  output logic               evParallel,
  output logic               evCondTrue,
  output logic               evCondFalse,
  output logic               evCondJump
);
  dp_ctl_t ctl;
  fmt_e    fmt;

  issue_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .fetchValid    (fetchValid),
    .fmt           (fmt),
    .leftTestOnly  (leftTestOnly),
    .rightTestOnly (rightTestOnly),
    .leftDone      (leftDone),
    .leftPcChanged (leftPcChanged),
    .leftExcept    (leftExcept),
    .leftCondTrue  (leftCondTrue),
    .rightDone     (rightDone),
    .rightPcChanged(rightPcChanged),
    .rightExcept   (rightExcept),
    .rightCondTrue (rightCondTrue),
    .ctl           (ctl),
    .flushReq      (flushReq),
    .wordDone      (wordDone),
    .evLong        (evLong),
    .evLeftRight   (evLeftRight),
    .evRightLeft   (evRightLeft),
    .evParallel    (evParallel),
    .evCondTrue    (evCondTrue),
    .evCondFalse   (evCondFalse),
    .evCondJump    (evCondJump)
  );

  issue_dp #(
    .WORD_W (WORD_W),
    .SHORT_W(SHORT_W),
    .KEY_W  (KEY_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .fetchWord (fetchWord),
    .fmt       (fmt),
    .longOp    (longOp),
    .longKey   (longKey),
    .leftOp    (leftOp),
    .leftKey   (leftKey),
    .rightOp   (rightOp),
    .rightKey  (rightKey),
    .issueLong (issueLong),
    .issueLeft (issueLeft),
    .issueRight(issueRight)
  );

endmodule

// File: tb/slot_issue_seq_tb_top.sv
module slot_issue_seq_tb_top;

  localparam int K_EVLONG = 0, K_EVLR = 1, K_EVRL = 2, K_EVPAR = 3,
                 K_EVCT = 4, K_EVCF = 5, K_EVCJ = 6, K_FLUSH = 7,
                 K_ISSLONG = 8, K_ISSL = 9, K_ISSR = 10, K_DONE = 11;

  typedef struct {
    int          kind;
    logic [29:0] data;
    logic [5:0]  key;
    string       req;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fetchValid = 1'b0;
  logic [31:0] fetchWord = '0;
  logic leftTestOnly = 1'b0, rightTestOnly = 1'b0;
  logic leftDone = 1'b0, leftPcChanged = 1'b0, leftExcept = 1'b0, leftCondTrue = 1'b0;
  logic rightDone = 1'b0, rightPcChanged = 1'b0, rightExcept = 1'b0, rightCondTrue = 1'b0;
  logic issueLong, issueLeft, issueRight, flushReq, wordDone;
  logic [29:0] longOp;
  logic [14:0] leftOp, rightOp;
  logic [5:0]  longKey, leftKey, rightKey;
  logic evLong, evLeftRight, evRightLeft, evParallel, evCondTrue, evCondFalse, evCondJump;

  // lane responses programmed per word
  logic lPc, lExc, lCond, rPc, rExc, rCond;

  item_t expQ[$];
  int checks = 0;
  int fails  = 0;
  int wordCount = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  slot_issue_seq dut_i (
    .clk(clk), .rst(rst), .fetchValid(fetchValid), .fetchWord(fetchWord),
    .leftTestOnly(leftTestOnly), .rightTestOnly(rightTestOnly),
    .leftDone(leftDone), .leftPcChanged(leftPcChanged), .leftExcept(leftExcept),
    .leftCondTrue(leftCondTrue), .rightDone(rightDone), .rightPcChanged(rightPcChanged),
    .rightExcept(rightExcept), .rightCondTrue(rightCondTrue),
    .issueLong(issueLong), .longOp(longOp), .longKey(longKey),
    .issueLeft(issueLeft), .leftOp(leftOp), .leftKey(leftKey),
    .issueRight(issueRight), .rightOp(rightOp), .rightKey(rightKey),
    .flushReq(flushReq), .wordDone(wordDone), .evLong(evLong),
    .evLeftRight(evLeftRight), .evRightLeft(evRightLeft), .evParallel(evParallel),
    .evCondTrue(evCondTrue), .evCondFalse(evCondFalse), .evCondJump(evCondJump)
  );

  task automatic pushExp(input int kind, input logic [29:0] data,
                         input logic [5:0] key, input string req);
    item_t it;
    it.kind = kind; it.data = data; it.key = key; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic compareItem(input int kind, input logic [29:0] data, input logic [5:0] key);
    item_t it;
    checks++;
    if (expQ.size() == 0) begin
      fails++;
      $display("FAIL R11 unexpected output kind=%0d data=%h key=%h, expected nothing", kind, data, key);
    end else begin
      it = expQ.pop_front();
      if (it.kind != kind || it.data != data || it.key != key) begin
        fails++;
        $display("FAIL %s actual kind=%0d data=%h key=%h expected kind=%0d data=%h key=%h",
                 it.req, kind, data, key, it.kind, it.data, it.key);
      end
    end
  endtask

  // monitor: scores every strobe in a fixed per-cycle order
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (evLong)      compareItem(K_EVLONG, '0, '0);
        if (evLeftRight) compareItem(K_EVLR, '0, '0);
        if (evRightLeft) compareItem(K_EVRL, '0, '0);
        if (evParallel)  compareItem(K_EVPAR, '0, '0);
        if (evCondTrue)  compareItem(K_EVCT, '0, '0);
        if (evCondFalse) compareItem(K_EVCF, '0, '0);
        if (evCondJump)  compareItem(K_EVCJ, '0, '0);
        if (flushReq)    compareItem(K_FLUSH, '0, '0);
        if (issueLong)   compareItem(K_ISSLONG, longOp, longKey);
        if (issueLeft)   compareItem(K_ISSL, {15'b0, leftOp}, leftKey);
        if (issueRight)  compareItem(K_ISSR, {15'b0, rightOp}, rightKey);
        if (wordDone) begin
          compareItem(K_DONE, '0, '0);
          wordCount++;
        end
      end
    end
  end

  // left lane (and long op) responder
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && (issueLeft || issueLong)) begin
        @(negedge clk);
        leftDone = 1'b1; leftPcChanged = lPc; leftExcept = lExc; leftCondTrue = lCond;
        @(negedge clk);
        leftDone = 1'b0; leftPcChanged = 1'b0; leftExcept = 1'b0; leftCondTrue = 1'b0;
      end
    end
  end

  // right lane responder
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && issueRight) begin
        @(negedge clk);
        rightDone = 1'b1; rightPcChanged = rPc; rightExcept = rExc; rightCondTrue = rCond;
        @(negedge clk);
        rightDone = 1'b0; rightPcChanged = 1'b0; rightExcept = 1'b0; rightCondTrue = 1'b0;
      end
    end
  end

  // driver: computes the expected stream from the requirements, then fetches
  task automatic runWord(input logic [31:0] w, input logic lt, input logic rt,
                         input logic [2:0] lf, input logic [2:0] rf,
                         input string req, input bit intrude);
    logic [14:0] lo, ro;
    int startCnt;
    lo = w[29:15];
    ro = w[14:0];
    {lPc, lExc, lCond} = lf;
    {rPc, rExc, rCond} = rf;
    leftTestOnly  = lt;
    rightTestOnly = rt;
    case (w[31:30])
      2'b11: begin
        pushExp(K_EVLONG, '0, '0, "R2");
        pushExp(K_ISSLONG, w[29:0], w[29:24], "R2");
      end
      2'b01: begin
        pushExp(K_EVLR, '0, '0, "R4");
        pushExp(K_ISSL, {15'b0, lo}, lo[14:9], "R3");
        if (!lf[2] && !lf[1]) begin
          pushExp(K_FLUSH, '0, '0, "R7");
          pushExp(K_ISSR, {15'b0, ro}, ro[14:9], req);
        end else if (!lf[1]) begin
          pushExp(K_EVCJ, '0, '0, "R6");
        end
      end
      2'b10: begin
        pushExp(K_EVRL, '0, '0, "R5");
        pushExp(K_ISSR, {15'b0, ro}, ro[14:9], "R3");
        if (!rf[2] && !rf[1]) begin
          pushExp(K_FLUSH, '0, '0, "R7");
          pushExp(K_ISSL, {15'b0, lo}, lo[14:9], req);
        end else if (!rf[1]) begin
          pushExp(K_EVCJ, '0, '0, "R6");
        end
      end
      default: begin
        pushExp(K_EVPAR, '0, '0, req);
        if (lt) begin
          pushExp(K_ISSL, {15'b0, lo}, lo[14:9], req);
          if (lf[0]) begin
            pushExp(K_EVCT, '0, '0, req);
            pushExp(K_ISSR, {15'b0, ro}, ro[14:9], req);
          end else pushExp(K_EVCF, '0, '0, req);
        end else if (rt) begin
          pushExp(K_ISSR, {15'b0, ro}, ro[14:9], req);
          if (rf[0]) begin
            pushExp(K_EVCT, '0, '0, req);
            pushExp(K_ISSL, {15'b0, lo}, lo[14:9], req);
          end else pushExp(K_EVCF, '0, '0, req);
        end else begin
          pushExp(K_ISSL, {15'b0, lo}, lo[14:9], req);
          if (!lf[1]) pushExp(K_ISSR, {15'b0, ro}, ro[14:9], req);
        end
      end
    endcase
    pushExp(K_DONE, '0, '0, "R11");
    startCnt = wordCount;
    @(negedge clk);
    fetchValid = 1'b1;
    fetchWord  = w;
    @(negedge clk);
    fetchValid = 1'b0;
    if (intrude) begin
      // R12: fetch strobe while the word is still in flight
      @(negedge clk);
      fetchValid = 1'b1;
      fetchWord  = 32'hC0FF_EE11;
      @(negedge clk);
      fetchValid = 1'b0;
    end
    wait (wordCount != startCnt);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if ({issueLong, issueLeft, issueRight, flushReq, wordDone, evLong, evLeftRight,
         evRightLeft, evParallel, evCondTrue, evCondFalse, evCondJump} !== 12'b0) begin
      fails++;
      $display("FAIL R1 outputs during reset actual=%b expected=0",
               {issueLong, issueLeft, issueRight, flushReq, wordDone});
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if ({issueLong, issueLeft, issueRight, flushReq, wordDone} !== 5'b0) begin
      fails++;
      $display("FAIL R1 outputs after reset actual=%b expected=0",
               {issueLong, issueLeft, issueRight, flushReq, wordDone});
    end

    // flags are {pcChanged, exception, condTrue}
    runWord(32'hD5A3_C5E1, 0, 0, 3'b000, 3'b000, "R2", 0);
    runWord(32'h5234_ABCD, 0, 0, 3'b000, 3'b000, "R4", 0);
    runWord(32'h5234_ABCD, 0, 0, 3'b100, 3'b000, "R6", 0);
    runWord(32'h4F0F_8001, 0, 0, 3'b010, 3'b000, "R6", 0);
    runWord(32'h4F0F_8001, 0, 0, 3'b110, 3'b000, "R6", 0);
    runWord(32'h9ABC_1357, 0, 0, 3'b000, 3'b000, "R5", 0);
    runWord(32'h9ABC_1357, 0, 0, 3'b000, 3'b100, "R6", 0);
    runWord(32'h9ABC_1357, 0, 0, 3'b000, 3'b010, "R6", 0);
    runWord(32'h1234_5678, 1, 0, 3'b001, 3'b000, "R8", 0);
    runWord(32'h1234_5678, 1, 0, 3'b000, 3'b001, "R8", 0);
    runWord(32'h2468_ACE0, 0, 1, 3'b001, 3'b001, "R9", 0);
    runWord(32'h2468_ACE0, 0, 1, 3'b001, 3'b000, "R9", 0);
    runWord(32'h3FFF_7FFF, 1, 1, 3'b001, 3'b000, "R8", 0);
    runWord(32'h0001_8000, 0, 0, 3'b000, 3'b000, "R10", 0);
    runWord(32'h0001_8000, 0, 0, 3'b010, 3'b000, "R10", 0);
    runWord(32'h6BAD_F00D, 0, 0, 3'b000, 3'b000, "R12", 1);
    runWord(32'h2222_5555, 0, 0, 3'b000, 3'b000, "R12", 1);

    repeat (6) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R11 missing outputs actual=%0d pending expected=0", expQ.size());
    end
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL R11 watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule